// File: doc/BRIEF.md
# Glitch-free system clock source selector

This block chooses the system clock from one of two free-running sources: a crystal oscillator clock and a PLL clock. A select input asks for the PLL. A self-clock flag, raised when the oscillator has failed, forces the PLL path whatever the select input says. The change of source is a handshake between the two clock domains. The old source is shut off on one of its own falling edges. Only after that shut-off has been seen in the new source's domain is the new source let through, again on one of its own falling edges. While this happens the system clock rests low, so every clock derived from it is frozen and the processor makes no progress.

From the selected clock the block drives a core clock and a bus clock at half the core rate. One processor cycle equals one bus period. It also drives two gated copies of the oscillator clock, one for a watchdog timer and one for a real-time-interrupt timer. Each has its own enable bit, its own choice of running during stop mode and its own choice of halting during wait mode. A PLL power output carries the software PLL-on request, but the block holds it high whenever the PLL is the requested or the active source.

The select, self-clock, mode and configuration inputs may change at any time with respect to either clock. A new source request is expected only once the previous switch has finished.

Top module: `sysclk_selector`

## Requirements
- R1: While rst_n is low and after it rises, the oscillator is the active source. in_transition is 0 and core_clk has the oscillator period.
- R2: Once a switch has finished, core_clk has the PLL period if the effective selection is 1, and the oscillator period if it is 0. The effective selection is pll_sel OR self_clk_mode.
- R3: The two source enables are never high together. No high or low phase of core_clk is shorter than half the shorter source period.
- R4: in_transition rises as soon as the effective selection differs from the active source. It falls no later than 4 oscillator periods plus 4 PLL periods after the selection change. core_clk is held low between the shut-off of the old source and the start of the new one.
- R5: With self_clk_mode at 1, the PLL becomes the active source even when pll_sel is 0. Clearing self_clk_mode with pll_sel at 0 returns the block to the oscillator.
- R6: pll_power is 1 whenever the effective selection is 1 or the PLL path is enabled, whatever pll_on_req is. Otherwise pll_power equals pll_on_req.
- R7: bus_clk is 0 during reset. After reset it toggles on every rising edge of core_clk, so its period is twice the core_clk period.
- R8: cop_clk carries osc_clk when cop_enable=1 and two further conditions hold: stop_mode=0 or cop_stop_run=1, and wait_mode=0 or cop_wait_halt=0. Otherwise cop_clk is held low. The change takes effect within three oscillator periods.
- R9: rti_clk follows the same rule as R8, using rti_enable, rti_stop_run and rti_wait_halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator source clock |
| pll_clk | input | 1 | PLL source clock |
| rst_n | input | 1 | Active-low reset, sampled in each clock domain |
| pll_sel | input | 1 | 1 requests the PLL as system clock source |
| pll_on_req | input | 1 | Software request to power the PLL |
| self_clk_mode | input | 1 | Oscillator-fail flag; forces the PLL source |
| stop_mode | input | 1 | Device is in stop mode |
| wait_mode | input | 1 | Device is in wait mode |
| cop_enable | input | 1 | Watchdog clock enable |
| cop_stop_run | input | 1 | Watchdog clock keeps running in stop mode |
| cop_wait_halt | input | 1 | Watchdog clock halts in wait mode |
| rti_enable | input | 1 | Real-time-interrupt clock enable |
| rti_stop_run | input | 1 | RTI clock keeps running in stop mode |
| rti_wait_halt | input | 1 | RTI clock halts in wait mode |
| core_clk | output | 1 | Selected system clock (core rate) |
| bus_clk | output | 1 | Core clock divided by two |
| cop_clk | output | 1 | Gated oscillator clock for the watchdog |
| rti_clk | output | 1 | Gated oscillator clock for the RTI timer |
| pll_power | output | 1 | PLL power control after the shut-off interlock |
| in_transition | output | 1 | High while a source change is pending |

## Verification
The hardest situation to reach is a source change in which the edges of the two unrelated clocks line up badly. In that case a short high or low sliver could reach core_clk, or the switch could overrun its 4-plus-4 cycle budget. The stimulus drives the two sources with periods that have no common ratio, and changes the selection several times at arbitrary phases. Switches are made both through pll_sel and through the self-clock flag. A monitor times every core_clk phase for the whole run. The switch time is measured from the selection change to the fall of in_transition. The PLL-off request is dropped while the PLL is in use, and pll_power is observed before and after the return to the oscillator.

// File: rtl/clksel_pkg.sv
// Package: shared types and helpers for the system clock selector.
// Assumes: nothing beyond IEEE 1800-2017.
package clksel_pkg;

    // Configuration of one gated timer clock
    typedef struct packed {
        logic enable;     // clock allowed at all
        logic stop_run;   // keep running while in stop mode
        logic wait_halt;  // halt while in wait mode
    } gate_cfg_t;

    // Decide whether a gated timer clock may run in the current mode
    function automatic logic gate_run(input gate_cfg_t cfg,
                                      input logic stop_m,
                                      input logic wait_m);
        return cfg.enable & (~stop_m | cfg.stop_run) & (~wait_m | ~cfg.wait_halt);
    endfunction

endpackage

// File: rtl/clksel_sync.sv
// Module: multi-stage synchronizer into the clock domain of clk.
// Assumes: d is asynchronous to clk; rst_n is held for several clk cycles.
module clksel_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    // Shift the asynchronous input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[LAST-1:0], d};
    end

    assign q = chain[LAST];
endmodule

// File: rtl/clksel_branch.sv
// Module: one source path of the glitch-free clock mux.
// The path asks to run only when it is wanted and the other path is off.
// The request is synchronized on rising edges, then the enable is taken on
// a falling edge so it only changes while the source clock is low.
// Assumes: want changes only after the previous switch has finished.
module clksel_branch #(
    parameter int   SYNC_STAGES = 2,
    parameter logic RESET_ON    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_en,
    output logic en,
    output logic gclk
);
    logic req;
    logic req_sync;
    logic en_q;

    assign req = want & ~other_en;

    clksel_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(RESET_ON)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req),
        .q    (req_sync)
    );

    // Move the enable only while the source clock is low
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= RESET_ON;
        else        en_q <= req_sync;
    end

    assign en   = en_q;
    assign gclk = clk & en_q;
endmodule

// File: rtl/clksel_gate.sv
// Module: glitch-free gate for a timer clock.
// The run request is synchronized into the clock domain, then latched on the
// falling edge, so the gated clock starts and stops only on full pulses.
// Assumes: run may change at any time relative to clk.
module clksel_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic en,
    output logic gclk
);
    logic run_sync;
    logic en_q;

    clksel_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b0)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (run),
        .q    (run_sync)
    );

    // Update the gate enable while the clock is low
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= run_sync;
    end

    assign en   = en_q;
    assign gclk = clk & en_q;
endmodule

// File: rtl/clksel_busdiv.sv
// Module: divides the core clock by two to form the bus clock.
// Assumes: the core clock runs during reset (the oscillator path is on).
module clksel_busdiv (
    input  logic core_clk,
    input  logic rst_n,
    output logic bus_clk
);
    logic half_q;

    // Toggle once per core rising edge
    always_ff @(posedge core_clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    assign bus_clk = half_q;
endmodule

// File: rtl/sysclk_selector.sv
// Module: system clock source selector (top).
// Picks the oscillator or the PLL clock with a break-before-make handshake.
// It derives the core and bus clocks and gates the watchdog and RTI clocks.
// Assumes: source change requests are spaced beyond one switch duration;
// rst_n is held low for several cycles of both source clocks.
module sysclk_selector #(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_GATES   = 2
) (
    input  logic osc_clk,
    input  logic pll_clk,
    input  logic rst_n,
    input  logic pll_sel,
    input  logic pll_on_req,
    input  logic self_clk_mode,
    input  logic stop_mode,
    input  logic wait_mode,
    input  logic cop_enable,
    input  logic cop_stop_run,
    input  logic cop_wait_halt,
    input  logic rti_enable,
    input  logic rti_stop_run,
    input  logic rti_wait_halt,
    output logic core_clk,
    output logic bus_clk,
    output logic cop_clk,
    output logic rti_clk,
    output logic pll_power,
    output logic in_transition
);
    import clksel_pkg::*;

    localparam int GATE_COP = 0;
    localparam int GATE_RTI = 1;

    logic                 sel_eff;
    logic                 osc_en;
    logic                 pll_en;
    logic                 osc_g;
    logic                 pll_g;
    gate_cfg_t            gate_cfg [NUM_GATES];
    logic [NUM_GATES-1:0] gate_en;
    logic [NUM_GATES-1:0] gate_clk;

    // Self-clock mode overrides the select bit
    assign sel_eff = pll_sel | self_clk_mode;

    clksel_branch #(
        .SYNC_STAGES(SYNC_STAGES),
        .RESET_ON   (1'b1)
    ) osc_path_i (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .want    (~sel_eff),
        .other_en(pll_en),
        .en      (osc_en),
        .gclk    (osc_g)
    );

    clksel_branch #(
        .SYNC_STAGES(SYNC_STAGES),
        .RESET_ON   (1'b0)
    ) pll_path_i (
        .clk     (pll_clk),
        .rst_n   (rst_n),
        .want    (sel_eff),
        .other_en(osc_en),
        .en      (pll_en),
        .gclk    (pll_g)
    );

    assign core_clk = osc_g | pll_g;

    // Pending until exactly the requested path is enabled
    assign in_transition = sel_eff ? (~pll_en | osc_en) : (~osc_en | pll_en);

    // PLL cannot be powered down while requested or in use
    assign pll_power = pll_on_req | sel_eff | pll_en;

    clksel_busdiv busdiv_i (
        .core_clk(core_clk),
        .rst_n   (rst_n),
        .bus_clk (bus_clk)
    );

    // Gather per-timer configuration
    always_comb begin
        for (int g = 0; g < NUM_GATES; g++) gate_cfg[g] = '0;
        gate_cfg[GATE_COP] = '{enable: cop_enable, stop_run: cop_stop_run, wait_halt: cop_wait_halt};
        gate_cfg[GATE_RTI] = '{enable: rti_enable, stop_run: rti_stop_run, wait_halt: rti_wait_halt};
    end

    for (genvar g = 0; g < NUM_GATES; g++) begin : gen_gate
        clksel_gate #(
            .SYNC_STAGES(SYNC_STAGES)
        ) gate_i (
            .clk  (osc_clk),
            .rst_n(rst_n),
            .run  (gate_run(gate_cfg[g], stop_mode, wait_mode)),
            .en   (gate_en[g]),
            .gclk (gate_clk[g])
        );
    end

    assign cop_clk = gate_clk[GATE_COP];
    assign rti_clk = gate_clk[GATE_RTI];
endmodule

// File: rtl/sysclk_selector_chk.sv
// Module: assertion checker bound to sysclk_selector.
// Assumes: default SYNC_STAGES of 2 (gate latency window of two samples).
module sysclk_selector_chk (
    input logic       osc_clk,
    input logic       pll_clk,
    input logic       rst_n,
    input logic       pll_sel,
    input logic       self_clk_mode,
    input logic       stop_mode,
    input logic       wait_mode,
    input logic       cop_enable,
    input logic       cop_stop_run,
    input logic       cop_wait_halt,
    input logic       rti_enable,
    input logic       rti_stop_run,
    input logic       rti_wait_halt,
    input logic       osc_en,
    input logic       pll_en,
    input logic       core_clk,
    input logic       bus_clk,
    input logic       pll_power,
    input logic [1:0] gate_en
);
    logic cop_allowed;
    logic rti_allowed;

    assign cop_allowed = cop_enable && !(stop_mode && !cop_stop_run) && !(wait_mode && cop_wait_halt);
    assign rti_allowed = rti_enable && !(stop_mode && !rti_stop_run) && !(wait_mode && rti_wait_halt);

    AST_EXCL_ON_OSC: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !(osc_en && pll_en)); // R3
    AST_EXCL_ON_PLL: assert property (@(posedge pll_clk) disable iff (!rst_n)
        !(osc_en && pll_en)); // R3
    AST_PLL_KEPT_ON: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (pll_sel || self_clk_mode || pll_en) |-> pll_power); // R6
    AST_BUS_TOGGLES: assert property (@(posedge core_clk) disable iff (!rst_n)
        $past(rst_n) |-> (bus_clk != $past(bus_clk))); // R7
    AST_COP_STOPPED: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ($past(!cop_allowed, 1) && $past(!cop_allowed, 2)) |-> !gate_en[0]); // R8
    AST_RTI_STOPPED: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ($past(!rti_allowed, 1) && $past(!rti_allowed, 2)) |-> !gate_en[1]); // R9
endmodule

bind sysclk_selector sysclk_selector_chk chk_i (
    .osc_clk      (osc_clk),
    .pll_clk      (pll_clk),
    .rst_n        (rst_n),
    .pll_sel      (pll_sel),
    .self_clk_mode(self_clk_mode),
    .stop_mode    (stop_mode),
    .wait_mode    (wait_mode),
    .cop_enable   (cop_enable),
    .cop_stop_run (cop_stop_run),
    .cop_wait_halt(cop_wait_halt),
    .rti_enable   (rti_enable),
    .rti_stop_run (rti_stop_run),
    .rti_wait_halt(rti_wait_halt),
    .osc_en       (osc_en),
    .pll_en       (pll_en),
    .core_clk     (core_clk),
    .bus_clk      (bus_clk),
    .pll_power    (pll_power),
    .gate_en      (gate_en)
);

// File: tb/sysclk_selector_tb_top.sv
`timescale 1ns/1ps
module sysclk_selector_tb_top;
    localparam real OSC_HALF = 4.0;   // 125 MHz oscillator
    localparam real PLL_HALF = 2.6;   // unrelated PLL period 5.2 ns
    localparam real TOL      = 0.02;
    localparam real SW_BOUND = 8.0 * OSC_HALF + 8.0 * PLL_HALF;

    // {stop, wait, cop_en, cop_sr, cop_wh, rti_en, rti_sr, rti_wh, exp_cop, exp_rti}
    localparam int NVEC = 8;
    localparam logic [9:0] GATE_VEC [NVEC] = '{
        10'b00_100_100_11,
        10'b00_000_000_00,
        10'b10_100_100_00,
        10'b10_110_100_10,
        10'b10_100_110_01,
        10'b01_100_100_11,
        10'b01_101_100_01,
        10'b01_100_101_10
    };

    logic osc_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
    logic pll_sel = 1'b0, pll_on_req = 1'b0, self_clk_mode = 1'b0;
    logic stop_mode = 1'b0, wait_mode = 1'b0;
    logic cop_enable = 1'b0, cop_stop_run = 1'b0, cop_wait_halt = 1'b0;
    logic rti_enable = 1'b0, rti_stop_run = 1'b0, rti_wait_halt = 1'b0;
    logic core_clk, bus_clk, cop_clk, rti_clk, pll_power, in_transition;

    int  n_checks = 0;
    int  n_errors = 0;
    real last_edge = 0.0;
    real min_phase = 1000.0;
    bit  mon_on = 1'b0;
    int  cop_cnt = 0;
    int  rti_cnt = 0;
    bit  finished = 1'b0;

    always #(OSC_HALF) osc_clk = ~osc_clk;
    always #(PLL_HALF) pll_clk = ~pll_clk;

    sysclk_selector dut_i (
        .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n),
        .pll_sel(pll_sel), .pll_on_req(pll_on_req), .self_clk_mode(self_clk_mode),
        .stop_mode(stop_mode), .wait_mode(wait_mode),
        .cop_enable(cop_enable), .cop_stop_run(cop_stop_run), .cop_wait_halt(cop_wait_halt),
        .rti_enable(rti_enable), .rti_stop_run(rti_stop_run), .rti_wait_halt(rti_wait_halt),
        .core_clk(core_clk), .bus_clk(bus_clk), .cop_clk(cop_clk), .rti_clk(rti_clk),
        .pll_power(pll_power), .in_transition(in_transition)
    );

    // Phase-width monitor on the core clock (R3)
    always @(core_clk) begin
        if (mon_on && ($realtime - last_edge) < min_phase) min_phase = $realtime - last_edge;
        last_edge = $realtime;
    end

    always @(posedge cop_clk) cop_cnt++;
    always @(posedge rti_clk) rti_cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
        end
    endtask

    task automatic measure_period(output real per);
        real t0;
        @(posedge core_clk); t0 = $realtime;
        @(posedge core_clk); per = $realtime - t0;
    endtask

    task automatic measure_bus(output real per);
        real t0;
        @(posedge bus_clk); t0 = $realtime;
        @(posedge bus_clk); per = $realtime - t0;
    endtask

    // Change the selection and time the switch (R4)
    task automatic do_switch(input bit sel, input bit scm, input string req);
        real t0;
        real dt;
        pll_sel = sel;
        self_clk_mode = scm;
        t0 = $realtime;
        #0.1;
        check(in_transition == 1'b1, "R4", {req, " transition flag raised"}, in_transition, 1.0);
        fork
            begin wait (in_transition == 1'b0); end
            begin #(SW_BOUND * 3.0); end
        join_any
        disable fork;
        dt = $realtime - t0;
        check(dt <= SW_BOUND, "R4", {req, " switch time"}, dt, SW_BOUND);
        repeat (3) @(negedge osc_clk);
    endtask

    initial begin
        #(200000.0);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        real per;
        repeat (20) @(negedge osc_clk);
        #0.3;
        // R1 and R7: reset state
        check(in_transition == 1'b0, "R1", "in_transition in reset", in_transition, 0.0);
        check(bus_clk == 1'b0, "R7", "bus_clk in reset", bus_clk, 0.0);
        check(pll_power == 1'b0, "R6", "pll_power in reset", pll_power, 0.0);
        @(negedge osc_clk); rst_n = 1'b1;
        repeat (4) @(negedge osc_clk);
        mon_on = 1'b1;
        measure_period(per);
        check(per > 2.0*OSC_HALF - TOL && per < 2.0*OSC_HALF + TOL, "R1", "core period after reset", per, 2.0*OSC_HALF);
        measure_bus(per);
        check(per > 4.0*OSC_HALF - TOL && per < 4.0*OSC_HALF + TOL, "R7", "bus period on osc", per, 4.0*OSC_HALF);

        // R2: move to PLL
        do_switch(1'b1, 1'b0, "R2");
        measure_period(per);
        check(per > 2.0*PLL_HALF - TOL && per < 2.0*PLL_HALF + TOL, "R2", "core period on pll", per, 2.0*PLL_HALF);
        measure_bus(per);
        check(per > 4.0*PLL_HALF - TOL && per < 4.0*PLL_HALF + TOL, "R7", "bus period on pll", per, 4.0*PLL_HALF);

        // R6: PLL-off request while PLL is selected is ignored
        pll_on_req = 1'b1; #3.3; pll_on_req = 1'b0; #5.1;
        check(pll_power == 1'b1, "R6", "pll_power held while pll selected", pll_power, 1.0);

        // R2: back to oscillator at an odd phase
        #1.7;
        do_switch(1'b0, 1'b0, "R2");
        measure_period(per);
        check(per > 2.0*OSC_HALF - TOL && per < 2.0*OSC_HALF + TOL, "R2", "core period back on osc", per, 2.0*OSC_HALF);
        check(pll_power == 1'b0, "R6", "pll_power follows request when osc active", pll_power, 0.0);
        pll_on_req = 1'b1; #0.5;
        check(pll_power == 1'b1, "R6", "pll_power on request", pll_power, 1.0);
        pll_on_req = 1'b0;

        // R5: self-clock mode forces PLL with pll_sel low
        #2.9;
        do_switch(1'b0, 1'b1, "R5");
        measure_period(per);
        check(per > 2.0*PLL_HALF - TOL && per < 2.0*PLL_HALF + TOL, "R5", "core period in self-clock mode", per, 2.0*PLL_HALF);
        check(pll_power == 1'b1, "R6", "pll_power in self-clock mode", pll_power, 1.0);
        #0.9;
        do_switch(1'b0, 1'b0, "R5");
        measure_period(per);
        check(per > 2.0*OSC_HALF - TOL && per < 2.0*OSC_HALF + TOL, "R5", "core period after self-clock clears", per, 2.0*OSC_HALF);

        // R3: narrowest phase seen across all switches
        check(min_phase >= PLL_HALF - TOL, "R3", "minimum core phase", min_phase, PLL_HALF);

        // R8 and R9: gating table
        for (int i = 0; i < NVEC; i++) begin
            {stop_mode, wait_mode, cop_enable, cop_stop_run, cop_wait_halt,
             rti_enable, rti_stop_run, rti_wait_halt} = GATE_VEC[i][9:2];
            repeat (6) @(negedge osc_clk);
            cop_cnt = 0; rti_cnt = 0;
            repeat (8) @(negedge osc_clk);
            check((cop_cnt > 0) == GATE_VEC[i][1], "R8", $sformatf("cop_clk activity vec %0d", i),
                  real'(cop_cnt), GATE_VEC[i][1] ? 8.0 : 0.0);
            check((rti_cnt > 0) == GATE_VEC[i][0], "R9", $sformatf("rti_clk activity vec %0d", i),
                  real'(rti_cnt), GATE_VEC[i][0] ? 8.0 : 0.0);
        end

        // R8: gated clock held low while disabled
        cop_enable = 1'b0; stop_mode = 1'b0; wait_mode = 1'b0;
        repeat (5) @(negedge osc_clk);
        #(OSC_HALF + 0.5);
        check(cop_clk == 1'b0, "R8", "cop_clk low in osc high phase when disabled", cop_clk, 0.0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule